// File: doc/BRIEF.md
# Audio/Video Byte Interleaver

This block feeds one byte-wide stream to a decoder that takes both audio and video on a shared bus. Bytes come from two FIFOs, each seen here as a head byte, a ready flag and a pop strobe. The block walks a fixed, repeating slot pattern. The pattern has N video slots and then one audio slot. N comes from a configuration input. The sequence moves forward by one slot on every clock, whether or not anything was sent.

The decoder throttles each stream with its own active-low request line. If the decoder has no request line for a stream, that input is tied low, which means the stream is always requested.

An audio slot may carry a video byte when no audio byte can be sent. A video slot never carries an audio byte. Each byte sent is marked by a valid strobe for its own stream. The FIFO that supplied the byte is popped in the same cycle.

Top module: `av_interleaver`

## Requirements
- R1: While `rst` is high, no strobe or pop is asserted and `byte_out` is zero. The first slot after `rst` falls is a video slot. The N used for that first pattern is the value of `cfg_vid_slots` at the last reset clock.
- R2: Slots follow the order N video slots, then one audio slot, and the pattern repeats with no gaps. The block advances exactly one slot per clock, whether or not the slot was filled.
- R3: `cfg_vid_slots` gives N directly for values 1 to 2^CNT_W-1. A value of 0 is treated as N = 1.
- R4: In a video slot, a video byte is sent exactly when `vid_ready` is 1 and `vid_req_n` is 0. An audio byte is never sent in a video slot.
- R5: In an audio slot, an audio byte is sent exactly when `aud_ready` is 1 and `aud_req_n` is 0.
- R6: In an audio slot where no audio byte can be sent (`aud_ready` is 0 or `aud_req_n` is 1), a video byte is sent instead when `vid_ready` is 1 and `vid_req_n` is 0.
- R7: A slot that nothing may fill asserts neither strobe nor pop, and `byte_out` is zero.
- R8: A new value of `cfg_vid_slots` has no effect on the pattern in progress. It is sampled on the clock that ends an audio slot and takes effect from the next pattern.
- R9: `vid_pop` equals `vid_strobe` and `aud_pop` equals `aud_strobe`. At most one of them is high in any cycle. `byte_out` carries the head byte of the FIFO being popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_vid_slots | input | CNT_W | Number of video slots per pattern (0 is treated as 1) |
| vid_data | input | DATA_W | Head byte of the video FIFO |
| vid_ready | input | 1 | Video FIFO holds at least one byte |
| vid_req_n | input | 1 | Decoder requests video, active low |
| aud_data | input | DATA_W | Head byte of the audio FIFO |
| aud_ready | input | 1 | Audio FIFO holds at least one byte |
| aud_req_n | input | 1 | Decoder requests audio, active low |
| vid_pop | output | 1 | Pop the video FIFO this cycle |
| aud_pop | output | 1 | Pop the audio FIFO this cycle |
| vid_strobe | output | 1 | `byte_out` holds a video byte |
| aud_strobe | output | 1 | `byte_out` holds an audio byte |
| byte_out | output | DATA_W | Output byte, zero when no strobe is high |

## Verification
The bench goes after the slot-stealing rules first.

- It starves audio, and separately withdraws the audio request. A design that leaves the audio slot idle in these cases loses video bandwidth. A design that lets audio into video slots breaks the fixed ratio.
- It drops the video request while audio is plentiful. Any video strobe in that test means the request was ignored.
- It programs N = 0 and changes N partway through a pattern. A wrong design would stall the counter at zero, or cut the current pattern short, and its audio strobes would then land in the wrong cycles.
- It changes the head bytes every cycle, so a swapped or stale data mux shows up at once.

// File: rtl/av_ilv_pkg.sv
package av_ilv_pkg;
  typedef enum logic {
    SLOT_VID = 1'b0,
    SLOT_AUD = 1'b1
  } slot_kind_e;
endpackage

// File: rtl/av_slot_seq.sv
module av_slot_seq
  import av_ilv_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cfg_n,
  output slot_kind_e       kind
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] idx_q;
  logic [CNT_W-1:0] n_act_q;
  logic [CNT_W-1:0] cfg_eff;
  logic             at_end;

  // zero maps to a single video slot
  assign cfg_eff = (cfg_n == '0) ? ONE : cfg_n;
  assign at_end  = (idx_q == n_act_q);
  assign kind    = at_end ? SLOT_AUD : SLOT_VID;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q   <= '0;
      n_act_q <= cfg_eff;
    end else if (at_end) begin
      idx_q   <= '0;
      n_act_q <= cfg_eff;   // new length only at pattern boundary
    end else begin
      idx_q   <= idx_q + ONE;
    end
  end

  assert_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    at_end |=> (idx_q == '0));
  assert_step_R2: assert property (@(posedge clk) disable iff (rst)
    !at_end |=> (idx_q == CNT_W'($past(idx_q) + ONE)));
  assert_len_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !at_end |=> $stable(n_act_q));
  assert_len_nonzero_R3: assert property (@(posedge clk) disable iff (rst)
    n_act_q != '0);
endmodule

// File: rtl/av_slot_arb.sv
module av_slot_arb
  import av_ilv_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  slot_kind_e kind,
  input  logic       vid_ready,
  input  logic       vid_req_n,
  input  logic       aud_ready,
  input  logic       aud_req_n,
  output logic       vid_grant,
  output logic       aud_grant
);
  logic vid_ok;
  logic aud_ok;
  logic aud_slot;

  assign vid_ok   = vid_ready & ~vid_req_n;
  assign aud_ok   = aud_ready & ~aud_req_n;
  assign aud_slot = (kind == SLOT_AUD);

  always_comb begin
    aud_grant = 1'b0;
    vid_grant = 1'b0;
    if (!rst) begin
      if (aud_slot) begin
        aud_grant = aud_ok;
        vid_grant = !aud_ok && vid_ok;   // steal an idle audio slot
      end else begin
        vid_grant = vid_ok;
      end
    end
  end

  assert_vslot_no_audio_R4: assert property (@(posedge clk) disable iff (rst)
    !aud_slot |-> !aud_grant);
  assert_steal_R6: assert property (@(posedge clk) disable iff (rst)
    (aud_slot && !aud_ok && vid_ok) |-> vid_grant);
  assert_vid_req_R4: assert property (@(posedge clk) disable iff (rst)
    vid_req_n |-> !vid_grant);
  assert_aud_req_R5: assert property (@(posedge clk) disable iff (rst)
    aud_req_n |-> !aud_grant);
endmodule

// File: rtl/av_byte_mux.sv
module av_byte_mux #(
  parameter int DATA_W = 8
) (
  input  logic              vid_sel,
  input  logic              aud_sel,
  input  logic [DATA_W-1:0] vid_data,
  input  logic [DATA_W-1:0] aud_data,
  output logic [DATA_W-1:0] byte_out
);
  // AND-OR select: zero output when neither source is chosen
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    assign byte_out[b] = (vid_sel & vid_data[b]) | (aud_sel & aud_data[b]);
  end
endmodule

// File: rtl/av_interleaver.sv
module av_interleaver
  import av_ilv_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  cfg_vid_slots,
  input  logic [DATA_W-1:0] vid_data,
  input  logic              vid_ready,
  input  logic              vid_req_n,
  input  logic [DATA_W-1:0] aud_data,
  input  logic              aud_ready,
  input  logic              aud_req_n,
  output logic              vid_pop,
  output logic              aud_pop,
  output logic              vid_strobe,
  output logic              aud_strobe,
  output logic [DATA_W-1:0] byte_out
);
  slot_kind_e kind;
  logic       vid_grant;
  logic       aud_grant;

  av_slot_seq #(.CNT_W(CNT_W)) u_seq (
    .clk   (clk),
    .rst   (rst),
    .cfg_n (cfg_vid_slots),
    .kind  (kind)
  );

  av_slot_arb u_arb (
    .clk       (clk),
    .rst       (rst),
    .kind      (kind),
    .vid_ready (vid_ready),
    .vid_req_n (vid_req_n),
    .aud_ready (aud_ready),
    .aud_req_n (aud_req_n),
    .vid_grant (vid_grant),
    .aud_grant (aud_grant)
  );

  av_byte_mux #(.DATA_W(DATA_W)) u_mux (
    .vid_sel  (vid_grant),
    .aud_sel  (aud_grant),
    .vid_data (vid_data),
    .aud_data (aud_data),
    .byte_out (byte_out)
  );

  assign vid_strobe = vid_grant;
  assign aud_strobe = aud_grant;
  assign vid_pop    = vid_grant;
  assign aud_pop    = aud_grant;

  assert_one_source_R9: assert property (@(posedge clk) disable iff (rst)
    !(vid_pop && aud_pop));
  assert_vid_byte_R9: assert property (@(posedge clk) disable iff (rst)
    vid_strobe |-> (byte_out == vid_data));
  assert_aud_byte_R9: assert property (@(posedge clk) disable iff (rst)
    aud_strobe |-> (byte_out == aud_data));
  assert_idle_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (!vid_strobe && !aud_strobe) |-> (byte_out == '0));
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |-> (!vid_pop && !aud_pop && byte_out == '0));
endmodule

// File: tb/sim_av_interleaver.sv
module sim_av_interleaver;
  localparam int DW = 8;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [CW-1:0] cfg = 4'd4;
  logic [DW-1:0] vd = '0, ad = '0;
  logic vr = 1'b0, vq = 1'b1, ar = 1'b0, aq = 1'b1;
  logic vpop, apop, vstb, astb;
  logic [DW-1:0] bout;

  int n_chk = 0, n_bad = 0;
  int m_idx = 0, m_n = 4;
  int cnt_vid = 0, cnt_aud = 0, step_no = 0;
  bit done = 0;

  always #10 clk = ~clk;

  av_interleaver #(.DATA_W(DW), .CNT_W(CW)) u0 (
    .clk(clk), .rst(rst), .cfg_vid_slots(cfg),
    .vid_data(vd), .vid_ready(vr), .vid_req_n(vq),
    .aud_data(ad), .aud_ready(ar), .aud_req_n(aq),
    .vid_pop(vpop), .aud_pop(apop), .vid_strobe(vstb), .aud_strobe(astb),
    .byte_out(bout));

  function automatic int eff(input logic [CW-1:0] c);
    return (c == 0) ? 1 : int'(c);
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  // called just after a negedge: drive, compare, advance one slot
  task automatic slot(input logic ivr, input logic [DW-1:0] ivd, input logic iar,
                      input logic [DW-1:0] iad, input logic ivq, input logic iaq,
                      input string tag);
    logic vok, aok, is_aud, ev, ea;
    logic [DW-1:0] eb;
    vr = ivr; vd = ivd; ar = iar; ad = iad; vq = ivq; aq = iaq;
    #1;
    vok = ivr & ~ivq;
    aok = iar & ~iaq;
    is_aud = (m_idx == m_n);
    ea = is_aud & aok;
    ev = is_aud ? (!aok && vok) : vok;
    eb = ev ? ivd : (ea ? iad : '0);
    check(tag, {vstb, astb, vpop, apop, bout}, {ev, ea, ev, ea, eb});
    cnt_vid += int'(vstb);
    cnt_aud += int'(astb);
    step_no++;
    @(posedge clk);
    if (m_idx == m_n) begin m_idx = 0; m_n = eff(cfg); end
    else m_idx++;
    @(negedge clk);
  endtask

  task automatic do_reset(input logic [CW-1:0] c);
    cfg = c;
    rst = 1'b1;
    vr = 1; ar = 1; vq = 0; aq = 0; vd = 8'h5A; ad = 8'hC3;
    repeat (2) @(posedge clk);
    @(negedge clk);
    #1;
    check("R1 quiet in reset", {vstb, astb, vpop, apop, bout}, '0);
    rst = 1'b0;
    m_idx = 0; m_n = eff(c);
    cnt_vid = 0; cnt_aud = 0; step_no = 0;
  endtask

  task automatic t_pattern;
    do_reset(4'd4);
    for (int i = 0; i < 15; i++)
      slot(1, 8'h10 + 8'(i), 1, 8'hA0 + 8'(i), 0, 0, "R2 pattern N=4");
    check("R2 audio count in 15 slots", 32'(cnt_aud), 32'd3);
    check("R2 video count in 15 slots", 32'(cnt_vid), 32'd12);
  endtask

  task automatic t_zero_len;
    do_reset(4'd0);
    for (int i = 0; i < 6; i++)
      slot(1, 8'h20 + 8'(i), 1, 8'hB0 + 8'(i), 0, 0, "R3 N=0 as 1");
    check("R3 alternation audio count", 32'(cnt_aud), 32'd3);
  endtask

  task automatic t_no_audio_in_vslot;
    do_reset(4'd3);
    for (int i = 0; i < 8; i++)
      slot(0, 8'h30, 1, 8'hD0 + 8'(i), 0, 0, "R4/R5 audio only in audio slot");
    check("R4 audio strobes with video empty", 32'(cnt_aud), 32'd2);
  endtask

  task automatic t_steal;
    do_reset(4'd2);
    for (int i = 0; i < 6; i++)
      slot(1, 8'h40 + 8'(i), 0, 8'hE1, 0, 0, "R6 steal, audio empty");
    for (int i = 0; i < 6; i++)
      slot(1, 8'h50 + 8'(i), 1, 8'hE2, 0, 1, "R6 steal, audio not requested");
    check("R6 video in every slot", 32'(cnt_vid), 32'd12);
    check("R6 no audio", 32'(cnt_aud), 32'd0);
  endtask

  task automatic t_vid_req;
    do_reset(4'd2);
    for (int i = 0; i < 6; i++)
      slot(1, 8'h60 + 8'(i), 1, 8'hF0 + 8'(i), 1, 0, "R4 video request high");
    check("R4 no video while request high", 32'(cnt_vid), 32'd0);
    for (int i = 0; i < 3; i++)
      slot(1, 8'h66, 0, 8'hF6, 1, 1, "R7 nothing eligible");
    check("R7 idle slots silent", 32'(cnt_aud), 32'd2);
  endtask

  task automatic t_len_change;
    int first_aud;
    first_aud = -1;
    do_reset(4'd5);
    for (int i = 0; i < 12; i++) begin
      if (i == 2) cfg = 4'd2;
      slot(1, 8'h70 + 8'(i), 1, 8'h90 + 8'(i), 0, 0, "R8 length change");
      if (first_aud < 0 && cnt_aud == 1) first_aud = i;
    end
    check("R8 old length finishes first", 32'(first_aud), 32'd5);
    check("R8 new length then applies", 32'(cnt_aud), 32'd3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_pattern();
    t_zero_len();
    t_no_audio_in_vslot();
    t_steal();
    t_vid_req();
    t_len_change();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule